// File: doc/BRIEF.md
# Output Fault Diagnostic Filter

This block qualifies raw fault comparator flags for an eight-channel bank of low-side power switches. It turns them into an 8-bit health word that the serial readout path shifts out. Each channel's commanded switch state picks which fault applies to it. A channel that is commanded on is judged on overcurrent. The two highest channels are also judged on thermal overload while on. A channel that is commanded off is judged on its output voltage sitting below the diagnostic threshold, which indicates an open load or a short to ground.

The two lowest channels carry a long time qualification: a condition must persist for a programmable number of clock cycles before it is reported. The other six channels report after a single register stage. Channels 1 to 6 also produce a shutdown request once overcurrent has persisted for a programmable delay. That request is held until the channel is commanded off or the block is reset. The health word is sampled into its output register on the falling edge of the serial chip select, so one read transaction sees one coherent snapshot.

Top module: `fault_diag_filter`

## Requirements
- R1: During and after a synchronous reset, `status` reads 8'hFF and `shut_req` reads 8'h00.
- R2: `status` loads the inverted filtered fault vector only at the clock edge that first sees `cs_n` low after it was high. At every other edge it keeps its value, including while faults change and when `cs_n` rises.
- R3: On channels 3 to 8 (bits 2 to 7), a commanded-off channel with `below_flag` set is reported as a fault (status bit 0) within three clock edges. `below_flag` has no effect on a commanded-on channel.
- R4: On channels 1 to 6 (bits 0 to 5), a commanded-on channel with `oc_flag` set is reported as a fault. `therm_flag` has no effect on these channels.
- R5: On channels 7 and 8 (bits 6 and 7), a commanded-on channel is reported as a fault when either `oc_flag` or `therm_flag` is set.
- R6: On channels 1 and 2 (bits 0 and 1), a condition is reported only after FILT_CYC consecutive clock edges with the condition present. A snapshot taken at edge FILT_CYC after the condition appears shows no fault, and one taken at edge FILT_CYC+2 shows the fault.
- R7: The qualification count of channels 1 and 2 restarts when the condition disappears for a cycle, and when the commanded state of the channel changes.
- R8: On channels 1 to 6, `shut_req[n]` rises after TRIP_CYC consecutive edges with the channel on and `oc_flag[n]` set. A shorter overcurrent run does not raise it.
- R9: A raised `shut_req[n]` stays high after `oc_flag[n]` clears, and it drops at the first edge that sees `cmd_on[n]` low.
- R10: `shut_req[7:6]` stays low whatever overcurrent the top two channels see.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Serial chip select, active low; its falling edge samples the health word |
| cmd_on | input | 8 | Commanded switch state per channel, 1 = on |
| oc_flag | input | 8 | Raw overcurrent comparator per channel |
| therm_flag | input | 8 | Raw thermal overload comparator per channel (used on bits 6 and 7 only) |
| below_flag | input | 8 | Raw output-below-diagnostic-threshold comparator per channel |
| status | output | 8 | Sampled health word, bit n-1 for channel n, 1 = no fault |
| shut_req | output | 8 | Latched overcurrent shutdown request per channel |

## Verification
The bench takes snapshots of the slow channels exactly one edge before and one edge after the qualification window completes. An off-by-one filter would report one edge early, or would still read healthy at the later edge. It breaks a condition for a single cycle, and separately flips the commanded state while the condition stays present. A counter that only pauses instead of restarting would then report a fault that should not exist. Overcurrent runs one cycle shorter than the trip delay must leave the shutdown low, and a latch that follows the raw flag would drop it when the flag clears. Cross-class stimulus (below-threshold while on, thermal on the low six channels, long overcurrent on the top two) exposes a wrong fault-class selection. Holding chip select low while a fault appears exposes a status register that tracks the level rather than the edge.

// File: rtl/fdf_pkg.sv
package fdf_pkg;

  // Selects the fault class that applies to a channel from its switch state.
  function automatic logic fault_cond(input logic on, input logic oc,
                                      input logic th, input logic below,
                                      input logic use_th);
    logic r;
    if (on) r = oc | (use_th & th);
    else    r = below;
    return r;
  endfunction

endpackage

// File: rtl/fdf_qual.sv
module fdf_qual #(
  parameter int LEN = 20
) (
  input  logic clk,
  input  logic rst,
  input  logic cmd_on,
  input  logic cond,
  output logic flt
);
  localparam int CW = $clog2(LEN + 1);
  localparam logic [CW-1:0] LIM = CW'(LEN);

  logic [CW-1:0] cnt;
  logic          cmd_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '0;
      cmd_q <= 1'b0;
    end else begin
      cmd_q <= cmd_on;
      if (!cond || (cmd_on != cmd_q)) cnt <= '0;
      else if (cnt != LIM)            cnt <= cnt + 1'b1;
    end
  end

  assign flt = (cnt == LIM);

  AST_QUAL_DROP: assert property (@(posedge clk) disable iff (rst)
    !cond |=> !flt); // R7

  AST_QUAL_CMD_FLIP: assert property (@(posedge clk) disable iff (rst)
    (cmd_on != cmd_q) |=> !flt); // R7

endmodule

// File: rtl/fdf_oc_trip.sv
module fdf_oc_trip #(
  parameter int TRIP_CYC = 5
) (
  input  logic clk,
  input  logic rst,
  input  logic cmd_on,
  input  logic oc,
  output logic shut
);
  localparam int CW = $clog2(TRIP_CYC) + 1;
  localparam logic [CW-1:0] LIM = CW'(TRIP_CYC - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !cmd_on) begin
      cnt  <= '0;
      shut <= 1'b0;
    end else if (!shut) begin
      if (oc) begin
        if (cnt == LIM) shut <= 1'b1;
        else            cnt  <= cnt + 1'b1;
      end else begin
        cnt <= '0;
      end
    end
  end

  AST_TRIP_CLEAR: assert property (@(posedge clk) disable iff (rst)
    !cmd_on |=> !shut); // R9

  AST_TRIP_HOLD: assert property (@(posedge clk) disable iff (rst)
    (shut && cmd_on) |=> shut); // R9

  AST_TRIP_CAUSE: assert property (@(posedge clk) disable iff (rst)
    $rose(shut) |-> $past(oc && cmd_on)); // R8

endmodule

// File: rtl/fdf_snap.sv
module fdf_snap #(
  parameter int NCH = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           cs_n,
  input  logic [NCH-1:0] fault,
  output logic [NCH-1:0] status
);
  logic cs_q;
  logic take;

  assign take = cs_q & ~cs_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      cs_q   <= 1'b1;
      status <= '1;
    end else begin
      cs_q <= cs_n;
      if (take) status <= ~fault;
    end
  end

  AST_SNAP_HOLD: assert property (@(posedge clk) disable iff (rst)
    !(cs_q && !cs_n) |=> $stable(status)); // R2

endmodule

// File: rtl/fault_diag_filter.sv
module fault_diag_filter #(
  parameter int NCH       = 8,
  parameter int NUM_SLOW  = 2,
  parameter int NUM_TRIP  = 6,
  parameter int NUM_THERM = 2,
  parameter int FILT_CYC  = 20,
  parameter int TRIP_CYC  = 5
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           cs_n,
  input  logic [NCH-1:0] cmd_on,
  input  logic [NCH-1:0] oc_flag,
  input  logic [NCH-1:0] therm_flag,
  input  logic [NCH-1:0] below_flag,
  output logic [NCH-1:0] status,
  output logic [NCH-1:0] shut_req
);
  import fdf_pkg::*;

  localparam int THERM_BASE = NCH - NUM_THERM;

  logic [NCH-1:0] cond;
  logic [NCH-1:0] flt;

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    localparam logic USE_TH = (i >= THERM_BASE);
    localparam int   LEN    = (i < NUM_SLOW) ? FILT_CYC : 1;

    assign cond[i] = fault_cond(cmd_on[i], oc_flag[i], therm_flag[i],
                                below_flag[i], USE_TH);

    fdf_qual #(.LEN(LEN)) u_qual (
      .clk    (clk),
      .rst    (rst),
      .cmd_on (cmd_on[i]),
      .cond   (cond[i]),
      .flt    (flt[i])
    );

    if (i < NUM_TRIP) begin : g_trip
      fdf_oc_trip #(.TRIP_CYC(TRIP_CYC)) u_trip (
        .clk    (clk),
        .rst    (rst),
        .cmd_on (cmd_on[i]),
        .oc     (oc_flag[i]),
        .shut   (shut_req[i])
      );
    end else begin : g_notrip
      assign shut_req[i] = 1'b0;
    end
  end

  fdf_snap #(.NCH(NCH)) u_snap (
    .clk    (clk),
    .rst    (rst),
    .cs_n   (cs_n),
    .fault  (flt),
    .status (status)
  );

endmodule

// File: tb/fault_diag_filter_bench.sv
module fault_diag_filter_bench;
  localparam int FILT = 20;
  localparam int TRIP = 5;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cs_n = 1'b1;
  logic [7:0] cmd_on = '0, oc_flag = '0, therm_flag = '0, below_flag = '0;
  logic [7:0] status, shut_req;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  fault_diag_filter #(.FILT_CYC(FILT), .TRIP_CYC(TRIP)) u_fault_diag_filter (
    .clk(clk), .rst(rst), .cs_n(cs_n), .cmd_on(cmd_on), .oc_flag(oc_flag),
    .therm_flag(therm_flag), .below_flag(below_flag),
    .status(status), .shut_req(shut_req)
  );

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; cs_n = 1'b1;
    cmd_on = '0; oc_flag = '0; therm_flag = '0; below_flag = '0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic snap(output logic [7:0] v);
    @(negedge clk);
    cs_n = 1'b0;
    @(posedge clk);
    @(negedge clk);
    v = status;
    cs_n = 1'b1;
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 status", status, 8'hFF);
    chk("R1 shut", shut_req, 8'h00);
  endtask

  task automatic t_off_below();
    logic [7:0] v;
    do_reset();
    below_flag = 8'hA4;
    repeat (3) @(posedge clk);
    snap(v);
    chk("R3 off below", v, 8'h5B);
  endtask

  task automatic t_on_masks();
    logic [7:0] v;
    do_reset();
    cmd_on = 8'hFF; below_flag = 8'hFF; therm_flag = 8'h3F;
    repeat (FILT + 3) @(posedge clk);
    snap(v);
    chk("R3 R4 on masks", v, 8'hFF);
    chk("R4 no trip", shut_req, 8'h00);
  endtask

  task automatic t_top_pair();
    logic [7:0] v;
    do_reset();
    cmd_on = 8'hFF; therm_flag = 8'hC0;
    repeat (3) @(posedge clk);
    snap(v);
    chk("R5 thermal", v, 8'h3F);
    @(negedge clk);
    therm_flag = 8'h00; oc_flag = 8'hC0;
    repeat (TRIP + 3) @(posedge clk);
    snap(v);
    chk("R5 overcurrent", v, 8'h3F);
    chk("R10 no trip", shut_req, 8'h00);
  endtask

  task automatic t_oc_mid();
    logic [7:0] v;
    do_reset();
    cmd_on = 8'hFF; oc_flag = 8'h08;
    repeat (3) @(posedge clk);
    snap(v);
    chk("R4 overcurrent", v, 8'hF7);
  endtask

  task automatic t_trip();
    do_reset();
    cmd_on = 8'hFF;
    repeat (2) @(posedge clk);
    @(negedge clk);
    oc_flag = 8'h08;
    repeat (TRIP - 1) @(posedge clk);
    @(negedge clk);
    chk("R8 short run", shut_req, 8'h00);
    oc_flag = 8'h00;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk("R8 after short", shut_req, 8'h00);
    oc_flag = 8'h08;
    repeat (TRIP) @(posedge clk);
    @(negedge clk);
    chk("R8 trip", shut_req, 8'h08);
    oc_flag = 8'h00;
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk("R9 hold", shut_req, 8'h08);
    cmd_on = 8'hF7;
    @(posedge clk);
    @(negedge clk);
    chk("R9 release", shut_req, 8'h00);
  endtask

  task automatic t_slow_boundary();
    logic [7:0] v;
    do_reset();
    below_flag = 8'h01;
    repeat (FILT - 1) @(posedge clk);
    snap(v);
    chk("R6 edge FILT", v, 8'hFF);
    snap(v);
    chk("R6 edge FILT+2", v, 8'hFE);
  endtask

  task automatic t_slow_restart();
    logic [7:0] v;
    do_reset();
    below_flag = 8'h01;
    repeat (FILT - 1) @(posedge clk);
    @(negedge clk);
    below_flag = 8'h00;
    @(posedge clk);
    @(negedge clk);
    below_flag = 8'h01;
    repeat (FILT - 1) @(posedge clk);
    snap(v);
    chk("R7 gap restart", v, 8'hFF);
  endtask

  task automatic t_cmd_restart();
    logic [7:0] v;
    do_reset();
    below_flag = 8'h02;
    repeat (FILT - 1) @(posedge clk);
    @(negedge clk);
    cmd_on = 8'h02; oc_flag = 8'h02; below_flag = 8'h00;
    repeat (FILT - 1) @(posedge clk);
    snap(v);
    chk("R7 cmd restart", v, 8'hFF);
    repeat (4) @(posedge clk);
    snap(v);
    chk("R6 on-state filtered", v, 8'hFD);
  endtask

  task automatic t_snap_hold();
    logic [7:0] v;
    do_reset();
    below_flag = 8'h04;
    cs_n = 1'b0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk("R2 hold while low", status, 8'hFF);
    cs_n = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R2 rise no load", status, 8'hFF);
    snap(v);
    chk("R2 fall load", v, 8'hFB);
  endtask

  initial begin
    t_reset();
    t_off_below();
    t_on_masks();
    t_top_pair();
    t_oc_mid();
    t_trip();
    t_slow_boundary();
    t_slow_restart();
    t_cmd_restart();
    t_snap_hold();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

endmodule